// File: doc/BRIEF.md
# Differential Preload Torque Amplitude Stage

This stage sits in the rebalance feedback loop at the high sample rate. It turns one signed rebalance command into two torquer drive amplitudes. The left amplitude is a preload bias plus the scaled command. The right amplitude is a second preload bias minus its own scaled command. Because the force from each torquer grows with the square of its amplitude, a large shared preload with opposite offsets gives a net torque that is linear in the command.

Each side has its own bias and its own unsigned gain. Mismatched plates can therefore be trimmed apart. Both results are limited to the non-negative range. This matters because a negative amplitude would break the linearisation. The outputs drive the digital-to-analog sigma-delta modulators that follow.

Configuration arrives on a small write port. Writes go into staging registers. A staged value is copied into the working set only on an accepted sample, so one sample is never computed with a mix of old and new settings.

Top module: `preload_torque_amp`

## Requirements
- R1: For every accepted sample, `amp_l_o` equals the clamped value of bias_l + round(cmd × gain_l / 2^15). All values are Q1.15, with the command and the bias in two's complement.
- R2: For every accepted sample, `amp_r_o` equals the clamped value of bias_r − round(cmd × gain_r / 2^15).
- R3: Each gain is an unsigned Q1.15 number, so 0x8000 means 1.0 and 0x4000 means 0.5. The scaled term is rounded half toward plus infinity: add 2^14, then shift right arithmetically by 15.
- R4: A result below zero is output as 0.
- R5: A result above 32767 is output as 32767.
- R6: `clamp_l_o` and `clamp_r_o` are per-side sticky flags. A flag is set in the same cycle as the output of a sample whose result on that side was clamped. Only reset clears it.
- R7: `amp_valid_o` is high exactly two clock edges after the edge that accepts `cmd_valid_i`. Between valid outputs, the amplitudes hold their last value.
- R8: The write addresses are: 0 left bias, 1 right bias, 2 left gain, 3 right gain. A write goes to staging. Staging is copied to the working set on each edge where `cmd_valid_i` is high, and the sample accepted on that edge still uses the previous working set.
- R9: After reset, the outputs are 0 and the flags and valid are low. Both biases are 0x4000 and both gains are 0x8000, in staging and in the working set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 16 | Signed Q1.15 rebalance command |
| cmd_valid_i | input | 1 | Command sample strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 2 | Configuration register select |
| cfg_wdata_i | input | 16 | Configuration write data |
| amp_l_o | output | 15 | Left torquer amplitude, Q0.15 |
| amp_r_o | output | 15 | Right torquer amplitude, Q0.15 |
| amp_valid_o | output | 1 | Amplitude strobe |
| clamp_l_o | output | 1 | Sticky left saturation flag |
| clamp_r_o | output | 1 | Sticky right saturation flag |

## Verification
Amplitudes, the valid strobe and the sticky flags are all due two rising edges after the edge that accepts a sample. The bench drives each sample on a falling edge and keeps the expected result of one call in flight. It compares that result at the falling edge that follows the second rising edge. A configuration write takes effect one accepted sample later than the write. The bench's model of staging and working registers copies on that same boundary, so the sample that straddles a write is checked against the old values.

// File: rtl/preload_torque_pkg.sv
package preload_torque_pkg;
  typedef enum logic [1:0] {
    CFG_BIAS_L = 2'd0,
    CFG_BIAS_R = 2'd1,
    CFG_GAIN_L = 2'd2,
    CFG_GAIN_R = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/preload_cfg_bank.sv
module preload_cfg_bank
  import preload_torque_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned GAIN_W   = 16,
  parameter int unsigned CFG_W    = 16,
  parameter logic [DATA_W-1:0] BIAS_RST = 16'h4000,
  parameter logic [GAIN_W-1:0] GAIN_RST = 16'h8000
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [1:0]                         addr_i,
  input  logic [CFG_W-1:0]                   wdata_i,
  input  logic                               commit_i,
  output logic [NUM_SIDES-1:0][DATA_W-1:0]   bias_o,
  output logic [NUM_SIDES-1:0][GAIN_W-1:0]   gain_o
);
  logic [NUM_SIDES-1:0][DATA_W-1:0] bias_stg;
  logic [NUM_SIDES-1:0][GAIN_W-1:0] gain_stg;

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    localparam logic [1:0] BIAS_SEL = (s == 0) ? CFG_BIAS_L : CFG_BIAS_R;
    localparam logic [1:0] GAIN_SEL = (s == 0) ? CFG_GAIN_L : CFG_GAIN_R;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bias_stg[s] <= BIAS_RST;
        gain_stg[s] <= GAIN_RST;
      end else if (we_i) begin
        if (addr_i == BIAS_SEL) bias_stg[s] <= wdata_i[DATA_W-1:0];
        if (addr_i == GAIN_SEL) gain_stg[s] <= wdata_i[GAIN_W-1:0];
      end
    end

    // working set swaps only on a sample boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bias_o[s] <= BIAS_RST;
        gain_o[s] <= GAIN_RST;
      end else if (commit_i) begin
        bias_o[s] <= bias_stg[s];
        gain_o[s] <= gain_stg[s];
      end
    end
  end
endmodule

// File: rtl/preload_lane.sv
module preload_lane #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned GAIN_W   = 16,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld1_i,
  input  logic              ld2_i,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic [DATA_W-1:0] bias_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DATA_W-2:0] amp_o,
  output logic              clamp_o
);
  localparam int unsigned GFRAC  = GAIN_W - 1;
  localparam int unsigned PROD_W = DATA_W + GAIN_W + 1;
  localparam int unsigned TERM_W = DATA_W + 2;
  localparam int unsigned SUM_W  = TERM_W + 1;
  localparam int unsigned AMP_W  = DATA_W - 1;
  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (GFRAC - 1);
  localparam logic signed [SUM_W-1:0]  AMP_MAX = SUM_W'((1 << AMP_W) - 1);

  logic signed [PROD_W-1:0] prod, prod_rnd, prod_sh;
  logic signed [TERM_W-1:0] term_d, term_q;
  logic signed [DATA_W-1:0] bias_q;
  logic signed [SUM_W-1:0]  sum;
  logic [AMP_W-1:0]         amp_d;
  logic                     sat;

  always_comb begin
    prod     = PROD_W'($signed(cmd_i)) * $signed({1'b0, gain_i});
    prod_rnd = prod + HALF;
    prod_sh  = prod_rnd >>> GFRAC;
    term_d   = prod_sh[TERM_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      term_q <= '0;
      bias_q <= '0;
    end else if (ld1_i) begin
      term_q <= term_d;
      bias_q <= $signed(bias_i);
    end
  end

  always_comb begin
    if (SUBTRACT) sum = SUM_W'(bias_q) - SUM_W'(term_q);
    else          sum = SUM_W'(bias_q) + SUM_W'(term_q);
    sat   = 1'b0;
    amp_d = sum[AMP_W-1:0];
    if (sum < 0) begin
      amp_d = '0;
      sat   = 1'b1;
    end else if (sum > AMP_MAX) begin
      amp_d = '1;
      sat   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_o   <= '0;
      clamp_o <= 1'b0;
    end else if (ld2_i) begin
      amp_o   <= amp_d;
      clamp_o <= clamp_o | sat;
    end
  end
endmodule

// File: rtl/preload_torque_amp.sv
module preload_torque_amp
  import preload_torque_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 16,
  parameter logic [DATA_W-1:0] BIAS_RST = 16'h4000,
  parameter logic [GAIN_W-1:0] GAIN_RST = 16'h8000,
  localparam int unsigned CFG_W = (DATA_W > GAIN_W) ? DATA_W : GAIN_W,
  localparam int unsigned AMP_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] cmd_i,
  input  logic              cmd_valid_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [AMP_W-1:0]  amp_l_o,
  output logic [AMP_W-1:0]  amp_r_o,
  output logic              amp_valid_o,
  output logic              clamp_l_o,
  output logic              clamp_r_o
);
  logic [NUM_SIDES-1:0][DATA_W-1:0] bias;
  logic [NUM_SIDES-1:0][GAIN_W-1:0] gain;
  logic [NUM_SIDES-1:0][AMP_W-1:0]  amp;
  logic [NUM_SIDES-1:0]             clamp;
  logic                             s1_vld;

  preload_cfg_bank #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .CFG_W(CFG_W),
    .BIAS_RST(BIAS_RST), .GAIN_RST(GAIN_RST)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .commit_i(cmd_valid_i),
    .bias_o(bias), .gain_o(gain)
  );

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_lane
    preload_lane #(
      .DATA_W(DATA_W), .GAIN_W(GAIN_W), .SUBTRACT(s == 1)
    ) u_lane (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .ld1_i(cmd_valid_i), .ld2_i(s1_vld),
      .cmd_i(cmd_i), .bias_i(bias[s]), .gain_i(gain[s]),
      .amp_o(amp[s]), .clamp_o(clamp[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld      <= 1'b0;
      amp_valid_o <= 1'b0;
    end else begin
      s1_vld      <= cmd_valid_i;
      amp_valid_o <= s1_vld;
    end
  end

  assign amp_l_o   = amp[0];
  assign amp_r_o   = amp[1];
  assign clamp_l_o = clamp[0];
  assign clamp_r_o = clamp[1];
endmodule

// File: rtl/preload_torque_amp_chk.sv
module preload_torque_amp_chk #(
  parameter int unsigned AMP_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [AMP_W-1:0] amp_l_o,
  input logic [AMP_W-1:0] amp_r_o,
  input logic             amp_valid_o,
  input logic             clamp_l_o,
  input logic             clamp_r_o
);
  // R7
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> ##2 amp_valid_o);
  // R7
  no_spur_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |-> ##2 !amp_valid_o);
  // R7
  hold_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_o |-> $stable(amp_l_o));
  // R7
  hold_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !amp_valid_o |-> $stable(amp_r_o));
  // R6
  sticky_l_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_l_o |=> clamp_l_o);
  // R6
  sticky_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clamp_r_o |=> clamp_r_o);
  // R6
  flag_set_on_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(clamp_l_o) || $rose(clamp_r_o)) |-> amp_valid_o);
endmodule

bind preload_torque_amp preload_torque_amp_chk #(.AMP_W(AMP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
  .amp_l_o(amp_l_o), .amp_r_o(amp_r_o), .amp_valid_o(amp_valid_o),
  .clamp_l_o(clamp_l_o), .clamp_r_o(clamp_r_o)
);

// File: tb/sim_preload_torque_amp.sv
module sim_preload_torque_amp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cmd_i = '0;
  logic        cmd_valid_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [14:0] amp_l_o, amp_r_o;
  logic        amp_valid_o, clamp_l_o, clamp_r_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int stg[4], act[4];
  bit p_v = 0, p_cl = 0, p_cr = 0;
  int p_l = 0, p_r = 0;
  bit m_cl = 0, m_cr = 0;

  always #2 clk_i = ~clk_i;

  preload_torque_amp u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_i(cmd_i), .cmd_valid_i(cmd_valid_i),
    .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
    .amp_l_o(amp_l_o), .amp_r_o(amp_r_o), .amp_valid_o(amp_valid_o),
    .clamp_l_o(clamp_l_o), .clamp_r_o(clamp_r_o)
  );

  // R1 R2 R3 R4 R5 model
  function automatic int side_amp(input int cmd, input int bias, input int gain,
                                  input bit sub, output bit sat);
    longint c, b, t, s;
    c = longint'($signed(16'(cmd)));
    b = longint'($signed(16'(bias)));
    t = (c * longint'(gain & 32'hFFFF) + 16384) >>> 15;
    s = sub ? b - t : b + t;
    sat = 1'b0;
    if (s < 0) begin s = 0; sat = 1'b1; end
    else if (s > 32767) begin s = 32767; sat = 1'b1; end
    return int'(s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic cyc(input bit v, input int cmd, input bit we, input int addr, input int data);
    int tmp[4];
    bit n_cl, n_cr;
    int n_l, n_r;
    cmd_valid_i = v; cmd_i = 16'(cmd);
    cfg_we_i = we; cfg_addr_i = 2'(addr); cfg_wdata_i = 16'(data);
    n_l = 0; n_r = 0; n_cl = 0; n_cr = 0;
    if (v) begin
      n_l = side_amp(cmd, act[0], act[2], 1'b0, n_cl);
      n_r = side_amp(cmd, act[1], act[3], 1'b1, n_cr);
    end
    // R8 staging/working model
    tmp = stg;
    if (we) stg[addr] = data & 32'hFFFF;
    if (v) act = tmp;
    @(posedge clk_i); @(negedge clk_i);
    chk(amp_valid_o == p_v, "R7 valid", amp_valid_o, p_v);
    if (p_v) begin
      m_cl |= p_cl; m_cr |= p_cr;
      chk(amp_l_o == 15'(p_l), "R1 left amp", amp_l_o, p_l);
      chk(amp_r_o == 15'(p_r), "R2 right amp", amp_r_o, p_r);
    end
    chk(clamp_l_o == m_cl, "R6 left flag", clamp_l_o, m_cl);
    chk(clamp_r_o == m_cr, "R6 right flag", clamp_r_o, m_cr);
    p_v = v; p_l = n_l; p_r = n_r; p_cl = n_cl; p_cr = n_cr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd1234));
    stg = '{16'h4000, 16'h4000, 16'h8000, 16'h8000};
    act = stg;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(amp_l_o == 0 && amp_r_o == 0, "R9 amps", amp_l_o, 0);
    chk(!amp_valid_o && !clamp_l_o && !clamp_r_o, "R9 flags", amp_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R9 defaults: cmd 0 -> 16384 both
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1000, 0, 0, 0);
    cyc(1, -1000, 0, 0, 0);
    idle(2);
    // R7 gaps between samples
    cyc(1, 300, 0, 0, 0); idle(1); cyc(1, -77, 0, 0, 0); idle(3);
    // R8 write, straddle sample uses old values
    cyc(0, 0, 1, 0, 16'h1000);
    cyc(0, 0, 1, 1, 16'h1000);
    cyc(0, 0, 1, 2, 16'h4000);
    cyc(0, 0, 1, 3, 16'h4000);
    cyc(1, 1, 0, 0, 0);          // still defaults: 16385 / 16383
    // R3 rounding: 0.5*1 -> 1, 0.5*-1 -> 0
    cyc(1, 1, 0, 0, 0);          // 4097 / 4095
    cyc(1, -1, 0, 0, 0);         // 4096 / 4096
    cyc(1, 3, 1, 2, 16'h8000);   // write coincident with sample
    cyc(1, 3, 0, 0, 0);          // old gain still
    cyc(1, 3, 0, 0, 0);          // new left gain
    idle(2);
    // R4 R5 clamps
    cyc(0, 0, 1, 0, 16'h6000);
    cyc(0, 0, 1, 1, 16'h0100);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 16'h7FFF, 0, 0, 0);   // left > max, right < 0
    cyc(1, 16'h8000, 0, 0, 0);
    idle(2);
    // random stream
    for (int i = 0; i < 3000; i++) begin
      bit v, we;
      r = $urandom_range(0, 9);
      v = (r < 7);
      we = ($urandom_range(0, 15) == 0);
      cyc(v, int'($urandom() & 32'hFFFF), we, int'($urandom_range(0, 3)),
          int'($urandom() & 32'hFFFF));
    end
    // directed extremes with zero gain
    cyc(0, 0, 1, 2, 0); cyc(0, 0, 1, 3, 0);
    cyc(0, 0, 1, 0, 16'h0005); cyc(0, 0, 1, 1, 16'hFFFB);
    cyc(1, 16'h8000, 0, 0, 0);
    cyc(1, 16'h7FFF, 0, 0, 0);   // 5 / 0
    idle(3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule